// File: doc/BRIEF.md
# Overcurrent Hiccup Protection Controller

This block is the digital fault sequencer that sits between a constant-on-time modulator and the gate drivers of a synchronous buck power stage. While the converter regulates, it passes the modulator's high-side and low-side gate requests straight through. It watches a digitized current sample of the low-side switch. When that sample exceeds a programmable limit while the low-side switch is conducting, the block takes control of the stage. It pulls the power-good line low and holds the soft-start reference at zero at once. It keeps the low-side switch on so that the inductor current can decay, and it releases the switch only once a sample reads zero.

After the current reaches zero, the block takes one of two paths. In the default hiccup mode, both switches stay off for a blanking interval, which is counted in pulses of an external tick strobe. The block then releases the soft-start reset, so the converter restarts through a full soft-start ramp. If the overload is still present, the whole cycle repeats. In latched mode, the stage stays off until the enable input is cycled, or until the bias supply cycles, which resets the block. A separate over-temperature flag forces every switch off for as long as it is set, and the converter restarts on its own once the flag clears.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: After reset, and whenever the block is disabled, both gate enables are 0 and both ss_rst_o and pg_kill_o are 1. If en_i is 1 and otp_i is 0, the block enters regulation at the next clock edge.
- R2: During regulation, hs_en_o follows pwm_hs_i and ls_en_o follows pwm_ls_i combinationally, and ss_rst_o and pg_kill_o are both 0.
- R3: lim_code_i is a limit in units of 0.5 A, and any code above 32 (16 A) acts as 32. isense_i is in the same 0.5 A units. A trip requires a sample strictly greater than the effective limit.
- R4: A sample is ignored when sample_vld_i is 0 or pwm_ls_i is 0, even if its value is above the limit.
- R5: At the clock edge that follows a trip, hs_en_o goes to 0, ls_en_o goes to 1, and ss_rst_o and pg_kill_o go to 1.
- R6: After a trip, ls_en_o stays 1 until a valid sample equal to 0 arrives. Samples that are invalid or nonzero do not release it.
- R7: In hiccup mode (latch_mode_i = 0), the zero sample starts a blanking interval with both switches off. The interval ends at the edge after blank_ticks_i pulses of tick_i have been counted, and regulation then resumes with ss_rst_o released.
- R8: An overload that persists after a restart trips again, and the drain-and-blank cycle repeats.
- R9: With latch_mode_i = 1, the zero sample latches the stage off. Ticks and temperature do not release the latch. Only en_i going to 0 clears it, and regulation then resumes once en_i returns to 1.
- R10: While otp_i is 1, both gate enables are 0 from the next edge onward. When otp_i clears with en_i at 1, regulation resumes at the next edge.
- R11: en_i at 0 forces the disabled state at the next edge from any state, including while the low-side switch is being held on after a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset (bias-supply cycle) |
| en_i | input | 1 | Converter enable request |
| otp_i | input | 1 | Over-temperature flag |
| latch_mode_i | input | 1 | 1 selects latched shutdown, 0 selects hiccup retry |
| lim_code_i | input | 6 | Overcurrent limit, 0.5 A per LSB, clamped at 32 |
| blank_ticks_i | input | 8 | Blanking length in tick_i pulses |
| tick_i | input | 1 | Time-base strobe for blanking |
| pwm_hs_i | input | 1 | Modulator high-side request |
| pwm_ls_i | input | 1 | Modulator low-side request |
| sample_vld_i | input | 1 | Current sample strobe |
| isense_i | input | 7 | Low-side current sample, 0.5 A per LSB |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| ss_rst_o | output | 1 | Holds the soft-start reference at zero |
| pg_kill_o | output | 1 | Forces power-good low |

## Verification
The hardest state to reach is a latched shutdown that was entered through a clamped limit. To get there, the limit code must be above 32, a sample exactly at the clamp must fail to trip, the next sample just above it must trip, and a zero sample must arrive while latched mode is selected. The stimulus builds this path step by step from a running converter. It then applies ticks to the latched state to show that they have no effect, and clears the latch by lowering the enable. The blanking interval is counted with sparse tick pulses so that the exit edge can be told apart from an exit driven by clock cycles.

// File: rtl/ocp_hiccup_pkg.sv
`timescale 1ns/1ps
package ocp_hiccup_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_RUN   = 3'd1,
      ST_DRAIN = 3'd2,
      ST_BLANK = 3'd3,
      ST_LATCH = 3'd4,
      ST_HOT   = 3'd5
   } ocp_state_e;

   typedef struct packed {
      logic hs;
      logic ls;
      logic ss_rst;
      logic pg_kill;
   } gate_cmd_t;

endpackage

// File: rtl/ocp_trip_cmp.sv
`timescale 1ns/1ps
module ocp_trip_cmp #(
   parameter int CODE_W   = 6,
   parameter int CUR_W    = 7,
   parameter int MAX_CODE = 32
) (
   input  logic [CODE_W-1:0] lim_code_i,
   input  logic [CUR_W-1:0]  isense_i,
   input  logic              sample_vld_i,
   input  logic              ls_on_i,
   output logic              trip_o,
   output logic              zero_o
);

   localparam int CODE_TOP = (1 << CODE_W) - 1;
   localparam bit NEED_CLAMP = (CODE_TOP > MAX_CODE);
   localparam logic [CODE_W-1:0] MAX_C = CODE_W'(MAX_CODE);

   if (CUR_W < CODE_W) begin : g_bad_width
      $error("ocp_trip_cmp: CUR_W must be at least CODE_W");
   end
   if (MAX_CODE > CODE_TOP) begin : g_bad_max
      $error("ocp_trip_cmp: MAX_CODE does not fit in CODE_W");
   end

   logic [CODE_W-1:0] lim_eff;

   if (NEED_CLAMP) begin : g_clamp
      assign lim_eff = (lim_code_i > MAX_C) ? MAX_C : lim_code_i;
   end else begin : g_pass
      assign lim_eff = lim_code_i;
   end

   logic [CUR_W-1:0] lim_ext;
   assign lim_ext = CUR_W'(lim_eff);

   assign trip_o = sample_vld_i && ls_on_i && (isense_i > lim_ext);
   assign zero_o = sample_vld_i && (isense_i == '0);

endmodule

// File: rtl/ocp_blank_timer.sv
`timescale 1ns/1ps
module ocp_blank_timer #(
   parameter int BLANK_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_i,
   input  logic               tick_i,
   input  logic [BLANK_W-1:0] limit_i,
   output logic               done_o
);

   if (BLANK_W < 1) begin : g_bad_w
      $error("ocp_blank_timer: BLANK_W must be positive");
   end

   logic [BLANK_W-1:0] cnt_q;

   assign done_o = (cnt_q >= limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
      end else if (tick_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ocp_fsm.sv
`timescale 1ns/1ps
module ocp_fsm
   import ocp_hiccup_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en_i,
   input  logic       otp_i,
   input  logic       latch_mode_i,
   input  logic       trip_i,
   input  logic       zero_i,
   input  logic       blank_done_i,
   input  logic       pwm_hs_i,
   input  logic       pwm_ls_i,
   output ocp_state_e state_o,
   output gate_cmd_t  cmd_o
);

   ocp_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (!en_i) begin
         st_d = ST_OFF;
      end else if (st_q == ST_LATCH) begin
         st_d = ST_LATCH;
      end else if (otp_i) begin
         st_d = ST_HOT;
      end else begin
         case (st_q)
            ST_OFF:   st_d = ST_RUN;
            ST_HOT:   st_d = ST_RUN;
            ST_RUN:   if (trip_i) st_d = ST_DRAIN;
            ST_DRAIN: if (zero_i) st_d = latch_mode_i ? ST_LATCH : ST_BLANK;
            ST_BLANK: if (blank_done_i) st_d = ST_RUN;
            default:  st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= st_d;
   end

   always_comb begin
      cmd_o = '{hs: 1'b0, ls: 1'b0, ss_rst: 1'b1, pg_kill: 1'b1};
      case (st_q)
         ST_RUN:   cmd_o = '{hs: pwm_hs_i, ls: pwm_ls_i, ss_rst: 1'b0, pg_kill: 1'b0};
         ST_DRAIN: cmd_o.ls = 1'b1;
         default:  ;
      endcase
   end

   assign state_o = st_q;

endmodule

// File: rtl/ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl
   import ocp_hiccup_pkg::*;
#(
   parameter int CODE_W   = 6,
   parameter int CUR_W    = 7,
   parameter int MAX_CODE = 32,
   parameter int BLANK_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_i,
   input  logic               otp_i,
   input  logic               latch_mode_i,
   input  logic [CODE_W-1:0]  lim_code_i,
   input  logic [BLANK_W-1:0] blank_ticks_i,
   input  logic               tick_i,
   input  logic               pwm_hs_i,
   input  logic               pwm_ls_i,
   input  logic               sample_vld_i,
   input  logic [CUR_W-1:0]   isense_i,
   output logic               hs_en_o,
   output logic               ls_en_o,
   output logic               ss_rst_o,
   output logic               pg_kill_o
);

   logic       trip, zero, blank_done;
   ocp_state_e st_q;
   gate_cmd_t  cmd;

   ocp_trip_cmp #(
      .CODE_W   (CODE_W),
      .CUR_W    (CUR_W),
      .MAX_CODE (MAX_CODE)
   ) u_cmp (
      .lim_code_i   (lim_code_i),
      .isense_i     (isense_i),
      .sample_vld_i (sample_vld_i),
      .ls_on_i      (pwm_ls_i),
      .trip_o       (trip),
      .zero_o       (zero)
   );

   ocp_blank_timer #(
      .BLANK_W (BLANK_W)
   ) u_blank (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (st_q == ST_BLANK),
      .tick_i  (tick_i),
      .limit_i (blank_ticks_i),
      .done_o  (blank_done)
   );

   ocp_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_i),
      .otp_i        (otp_i),
      .latch_mode_i (latch_mode_i),
      .trip_i       (trip),
      .zero_i       (zero),
      .blank_done_i (blank_done),
      .pwm_hs_i     (pwm_hs_i),
      .pwm_ls_i     (pwm_ls_i),
      .state_o      (st_q),
      .cmd_o        (cmd)
   );

   assign hs_en_o   = cmd.hs;
   assign ls_en_o   = cmd.ls;
   assign ss_rst_o  = cmd.ss_rst;
   assign pg_kill_o = cmd.pg_kill;

endmodule

// File: rtl/ocp_hiccup_chk.sv
`timescale 1ns/1ps
module ocp_hiccup_chk
   import ocp_hiccup_pkg::*;
#(
   parameter int CODE_W   = 6,
   parameter int CUR_W    = 7,
   parameter int MAX_CODE = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_i,
   input logic              otp_i,
   input logic              pwm_ls_i,
   input logic              sample_vld_i,
   input logic [CODE_W-1:0] lim_code_i,
   input logic [CUR_W-1:0]  isense_i,
   input ocp_state_e        st_i,
   input logic              hs_en_o,
   input logic              ls_en_o,
   input logic              ss_rst_o,
   input logic              pg_kill_o
);

   logic [CUR_W-1:0] lim_chk;
   assign lim_chk = (int'(lim_code_i) > MAX_CODE) ? CUR_W'(MAX_CODE) : CUR_W'(lim_code_i);

   // R5: an over-limit low-side sample during regulation hands the stage to the drain phase
   assert_trip_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == ST_RUN && en_i && !otp_i && sample_vld_i && pwm_ls_i && isense_i > lim_chk)
      |=> (ls_en_o && !hs_en_o && ss_rst_o && pg_kill_o));

   // R6: the low-side switch is held until a valid zero sample
   assert_drain_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == ST_DRAIN && en_i && !otp_i && !(sample_vld_i && isense_i == '0))
      |=> (ls_en_o && !hs_en_o));

   // R9: only the enable releases a latched shutdown
   assert_latch_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == ST_LATCH && en_i) |=> (st_i == ST_LATCH && !hs_en_o && !ls_en_o));

   // R10: over-temperature stops all switching
   assert_otp_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      otp_i |=> (!hs_en_o && !ls_en_o && ss_rst_o));

   // R11: disable is a hard shutdown from any state
   assert_disable_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!hs_en_o && !ls_en_o && ss_rst_o && pg_kill_o));

endmodule

bind ocp_hiccup_ctrl ocp_hiccup_chk #(
   .CODE_W   (CODE_W),
   .CUR_W    (CUR_W),
   .MAX_CODE (MAX_CODE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en_i         (en_i),
   .otp_i        (otp_i),
   .pwm_ls_i     (pwm_ls_i),
   .sample_vld_i (sample_vld_i),
   .lim_code_i   (lim_code_i),
   .isense_i     (isense_i),
   .st_i         (st_q),
   .hs_en_o      (hs_en_o),
   .ls_en_o      (ls_en_o),
   .ss_rst_o     (ss_rst_o),
   .pg_kill_o    (pg_kill_o)
);

// File: tb/sim_ocp_hiccup_ctrl.sv
`timescale 1ns/1ps
module sim_ocp_hiccup_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0, otp = 1'b0, latch_mode = 1'b0;
   logic [5:0] lim_code = 6'd20;
   logic [7:0] blank_ticks = 8'd3;
   logic       tick = 1'b0, pwm_hs = 1'b0, pwm_ls = 1'b0, vld = 1'b0;
   logic [6:0] isense = '0;
   logic       hs, ls, ss, pg;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #2.5 clk = ~clk;

   ocp_hiccup_ctrl u0 (
      .clk (clk), .rst_n (rst_n), .en_i (en), .otp_i (otp),
      .latch_mode_i (latch_mode), .lim_code_i (lim_code),
      .blank_ticks_i (blank_ticks), .tick_i (tick),
      .pwm_hs_i (pwm_hs), .pwm_ls_i (pwm_ls), .sample_vld_i (vld),
      .isense_i (isense), .hs_en_o (hs), .ls_en_o (ls),
      .ss_rst_o (ss), .pg_kill_o (pg)
   );

   // Expected bits: {hs, ls, ss_rst, pg_kill} one edge after the drive
   task automatic drv(input logic e, input logic t, input logic ph, input logic pl,
                      input logic v, input logic [6:0] cur, input logic tk,
                      input logic [3:0] expv, input string tag);
      @(negedge clk);
      en = e; otp = t; pwm_hs = ph; pwm_ls = pl; vld = v; isense = cur; tick = tk;
      exp_q.push_back(expv);
      tag_q.push_back(tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [3:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if ({hs, ls, ss, pg} !== e) begin
            fails++;
            $display("FAIL %s: got {hs,ls,ss,pg}=%b expected %b", t, {hs, ls, ss, pg}, e);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      checks++;
      if ({hs, ls, ss, pg} !== 4'b0011) begin
         fails++;
         $display("FAIL R1 reset: got %b expected 0011", {hs, ls, ss, pg});
      end
      @(negedge clk); rst_n = 1'b1;
      drv(0,0,1,0,0,0,0, 4'b0011, "R1 disabled after reset");
      drv(1,0,1,0,0,0,0, 4'b1000, "R1 R2 enable enters regulation hs");
      drv(1,0,0,1,1,7'd20,0, 4'b0100, "R2 R3 sample at limit no trip");
      drv(1,0,1,0,1,7'd40,0, 4'b1000, "R4 ignored with low side off");
      drv(1,0,0,1,0,7'd40,0, 4'b0100, "R4 ignored without strobe");
      drv(1,0,0,1,1,7'd21,0, 4'b0111, "R5 trip above limit");
      drv(1,0,1,0,1,7'd10,0, 4'b0111, "R6 nonzero sample holds low side");
      drv(1,0,1,0,0,7'd0,0,  4'b0111, "R6 invalid zero holds low side");
      drv(1,0,1,0,1,7'd0,0,  4'b0011, "R6 R7 zero sample enters blanking");
      drv(1,0,1,0,0,0,1, 4'b0011, "R7 blank tick 1");
      drv(1,0,1,0,0,0,0, 4'b0011, "R7 blank no tick");
      drv(1,0,1,0,0,0,1, 4'b0011, "R7 blank tick 2");
      drv(1,0,1,0,0,0,1, 4'b0011, "R7 blank tick 3 counted");
      drv(1,0,1,0,0,0,0, 4'b1000, "R7 restart after blanking");
      drv(1,0,0,1,1,7'd50,0, 4'b0111, "R8 persistent overload trips again");
      drv(1,0,0,0,1,7'd0,0,  4'b0011, "R8 second blanking");
      drv(1,0,0,0,0,0,1, 4'b0011, "R8 tick 1");
      drv(1,0,0,0,0,0,1, 4'b0011, "R8 tick 2");
      drv(1,0,0,0,0,0,1, 4'b0011, "R8 tick 3");
      drv(1,0,0,1,0,0,0, 4'b0100, "R8 second restart");
      lim_code = 6'd63;
      drv(1,0,0,1,1,7'd32,0, 4'b0100, "R3 clamp at 32 no trip");
      drv(1,0,0,1,1,7'd33,0, 4'b0111, "R3 clamp trip above 32");
      latch_mode = 1'b1;
      drv(1,0,0,0,1,7'd0,0, 4'b0011, "R9 zero enters latch");
      drv(1,0,1,0,0,0,1, 4'b0011, "R9 latch ignores tick");
      drv(1,0,1,0,0,0,1, 4'b0011, "R9 latch ignores tick again");
      drv(1,1,1,0,0,0,0, 4'b0011, "R9 latch ignores temperature");
      drv(1,0,1,0,0,0,1, 4'b0011, "R9 still latched after temperature");
      drv(0,0,1,0,0,0,0, 4'b0011, "R9 R11 enable low clears latch");
      drv(1,0,1,0,0,0,0, 4'b1000, "R9 restart after enable cycle");
      latch_mode = 1'b0;
      drv(1,1,1,0,0,0,0, 4'b0011, "R10 temperature stops switching");
      drv(1,1,1,1,0,0,0, 4'b0011, "R10 held off while hot");
      drv(1,0,1,0,0,0,0, 4'b1000, "R10 auto restart");
      drv(1,0,0,1,1,7'd40,0, 4'b0111, "R5 trip for shutdown test");
      drv(0,0,0,1,1,7'd40,0, 4'b0011, "R11 disable during drain");
      drv(0,0,1,1,0,0,0, 4'b0011, "R11 stays off while disabled");
      drv(1,0,0,0,0,0,0, 4'b0000, "R1 re-enable");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule